// File: doc/BRIEF.md
# Interleaved Task Issue Scheduler with Exclusive Lock

This block decides, on every clock, which of several hardware tasks sharing one core may issue next. With no lock in force, the enabled tasks take turns in a fixed rotation and disabled tasks are skipped. Any task may take exclusive ownership of the issue slots with a lock strobe. From then on every slot goes to that task until it hands the slots back with a free strobe. The owner's long operation must also have drained, and the lock is dropped if the owner is disabled.

A mode register adds an atomic policy. While it is on, the scheduler does not rotate away from the current task as long as that task reports a long operation or a delayed branch in flight. A debug setting turns the policy off, so rotation continues regardless of pending work. The chosen task number and a valid bit are registered outputs, and each one reflects the inputs sampled at the previous rising edge.

Top module: `task_slot_sched`

## Requirements
- R1: After a synchronous active-low reset, `sel_tid` is 0, `sel_valid` is 0, no lock is held and the atomic policy is off, so a pending long operation does not stop rotation.
- R2: With no lock and no atomic hold, each edge selects the first task with its `task_en` bit set (bit n is task n) that follows the current one in ascending order with wrap-around. If no task is enabled, `sel_valid` is 0.
- R3: A `lock_req` naming an enabled task in `lock_tid`, while no lock is held, makes that task the selection from the next edge on, every cycle.
- R4: A `free_req` whose `free_tid` equals the lock owner releases the lock when the owner's `long_busy` bit is 0. Rotation resumes from the owner on that same edge.
- R5: A matching free that arrives while the owner's `long_busy` bit is 1 is remembered. The owner keeps every slot until the first edge at which that bit is 0, and the lock is released on that edge.
- R6: A `lock_req` while a lock is held is ignored, and a `free_req` naming a task other than the owner is ignored.
- R7: If the owner's `task_en` bit is 0, the lock is cleared on the next edge and rotation continues. A `lock_req` naming a disabled task is ignored.
- R8: A `set_atomic` pulse turns the atomic policy on from the next edge. While it is on, a selected, enabled task whose `long_busy` bit is 1 stays selected.
- R9: A `set_debug` pulse turns the atomic policy off from the next edge and wins over a simultaneous `set_atomic`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| task_en | input | NUM_TASKS | Per-task enable, bit n is task n |
| lock_req | input | 1 | Lock strobe |
| lock_tid | input | TID_W | Task asking for the lock |
| free_req | input | 1 | Free strobe |
| free_tid | input | TID_W | Task giving up the lock |
| long_busy | input | NUM_TASKS | Per-task flag: long operation or delayed branch pending |
| set_atomic | input | 1 | Pulse: turn the atomic policy on |
| set_debug | input | 1 | Pulse: turn the atomic policy off |
| sel_tid | output | TID_W | Task granted this slot |
| sel_valid | output | 1 | A task is granted |

## Verification
The bench builds the block with its default of four tasks and a two-bit task number. This size is enough to reach the wrap from task 3 to task 0, sparse enable patterns where the rotation must jump over gaps, and a lock owner that is disabled while the others keep running. It drives the deferred-release path, in which a free arrives during a long operation. It also hits the cycle right after a debug pulse, when the old atomic policy still applies to that edge.

// File: rtl/sched_pkg.sv
// Shared definitions for the task slot scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package sched_pkg;
    localparam int DEF_TASKS = 4;

    typedef enum logic {
        MODE_DEBUG  = 1'b0,
        MODE_ATOMIC = 1'b1
    } sched_mode_e;
endpackage

// File: rtl/sched_lock_ctrl.sv
// Lock ownership state for the scheduler. Grants the lock to an enabled
// requester when free, releases it on a matching free once the owner has no
// long operation pending, and drops it if the owner is disabled.
// Assumes: lock_tid/free_tid are below NUM_TASKS.
module sched_lock_ctrl #(
    parameter int NUM_TASKS = 4,
    localparam int TID_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TASKS-1:0] task_en,
    input  logic [NUM_TASKS-1:0] long_busy,
    input  logic                 lock_req,
    input  logic [TID_W-1:0]     lock_tid,
    input  logic                 free_req,
    input  logic [TID_W-1:0]     free_tid,
    output logic                 lock_nxt,
    output logic [TID_W-1:0]     owner_nxt,
    output logic                 lock_q,
    output logic [TID_W-1:0]     owner_q
);
    logic pend_q, pend_nxt;
    logic free_hit;

    assign free_hit = free_req && (free_tid == owner_q);

    // Next lock state from current ownership and this cycle's strobes.
    always_comb begin
        lock_nxt  = lock_q;
        owner_nxt = owner_q;
        pend_nxt  = pend_q;
        if (lock_q) begin
            if (!task_en[owner_q]) begin
                lock_nxt = 1'b0;
                pend_nxt = 1'b0;
            end else if (free_hit || pend_q) begin
                if (long_busy[owner_q]) begin
                    pend_nxt = 1'b1;
                end else begin
                    lock_nxt = 1'b0;
                    pend_nxt = 1'b0;
                end
            end
        end else if (lock_req && task_en[lock_tid]) begin
            lock_nxt  = 1'b1;
            owner_nxt = lock_tid;
            pend_nxt  = 1'b0;
        end
    end

    // Lock state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            owner_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            lock_q  <= lock_nxt;
            owner_q <= owner_nxt;
            pend_q  <= pend_nxt;
        end
    end

    AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && task_en[owner_q]) |=> (!lock_q || owner_q == $past(owner_q))); // R6

    AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !task_en[owner_q]) |=> !lock_q); // R7

    AST_BUSY_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && task_en[owner_q] && long_busy[owner_q]) |=> lock_q); // R5
endmodule

// File: rtl/sched_rr_pick.sv
// Rotation picker: returns the first enabled task after the current one,
// in ascending order with wrap, the current task being tried last.
// Assumes: cur_tid is below NUM_TASKS.
module sched_rr_pick #(
    parameter int NUM_TASKS = 4,
    localparam int TID_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic [TID_W-1:0]     cur_tid,
    input  logic [NUM_TASKS-1:0] task_en,
    output logic [TID_W-1:0]     pick_tid,
    output logic                 pick_any
);
    // Scan from the farthest offset down so the nearest enabled task wins.
    always_comb begin
        pick_tid = cur_tid;
        pick_any = |task_en;
        for (int k = NUM_TASKS; k >= 1; k--) begin
            int idx;
            idx = int'(cur_tid) + k;
            if (idx >= NUM_TASKS) idx = idx - NUM_TASKS;
            if (task_en[idx]) pick_tid = TID_W'(idx);
        end
    end
endmodule

// File: rtl/task_slot_sched.sv
// Task slot scheduler top. Registers one granted task per clock: the lock
// owner if a lock is in force, else the current task if the atomic policy
// holds it, else the next enabled task in rotation.
// Assumes: inputs synchronous to clk; outputs lag inputs by one edge.
module task_slot_sched #(
    parameter int NUM_TASKS = sched_pkg::DEF_TASKS,
    localparam int TID_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TASKS-1:0] task_en,
    input  logic                 lock_req,
    input  logic [TID_W-1:0]     lock_tid,
    input  logic                 free_req,
    input  logic [TID_W-1:0]     free_tid,
    input  logic [NUM_TASKS-1:0] long_busy,
    input  logic                 set_atomic,
    input  logic                 set_debug,
    output logic [TID_W-1:0]     sel_tid,
    output logic                 sel_valid
);
    import sched_pkg::*;

    sched_mode_e       mode_q;
    logic              lock_nxt, lock_q;
    logic [TID_W-1:0]  owner_nxt, owner_q;
    logic [TID_W-1:0]  pick_tid;
    logic              pick_any;
    logic              hold;

    sched_lock_ctrl #(.NUM_TASKS(NUM_TASKS)) i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .task_en   (task_en),
        .long_busy (long_busy),
        .lock_req  (lock_req),
        .lock_tid  (lock_tid),
        .free_req  (free_req),
        .free_tid  (free_tid),
        .lock_nxt  (lock_nxt),
        .owner_nxt (owner_nxt),
        .lock_q    (lock_q),
        .owner_q   (owner_q)
    );

    sched_rr_pick #(.NUM_TASKS(NUM_TASKS)) i_pick (
        .cur_tid  (sel_tid),
        .task_en  (task_en),
        .pick_tid (pick_tid),
        .pick_any (pick_any)
    );

    // Atomic hold: stay on a granted task that still has work in flight.
    assign hold = (mode_q == MODE_ATOMIC) && sel_valid &&
                  task_en[sel_tid] && long_busy[sel_tid];

    // Policy register; debug takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode_q <= MODE_DEBUG;
        else if (set_debug)  mode_q <= MODE_DEBUG;
        else if (set_atomic) mode_q <= MODE_ATOMIC;
    end

    // Grant register: lock owner, then atomic hold, then rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_tid   <= '0;
            sel_valid <= 1'b0;
        end else if (lock_nxt) begin
            sel_tid   <= owner_nxt;
            sel_valid <= 1'b1;
        end else if (hold) begin
            sel_valid <= 1'b1;
        end else begin
            sel_tid   <= pick_tid;
            sel_valid <= pick_any;
        end
    end

    AST_LOCK_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> (sel_valid && sel_tid == owner_q)); // R3

    AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (!sel_valid || ($past(task_en) & (NUM_TASKS'(1) << sel_tid)) != '0)); // R2

    AST_ATOMIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !lock_req) |=> (sel_tid == $past(sel_tid) && sel_valid)); // R8

    AST_DEBUG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_debug |=> (mode_q == MODE_DEBUG)); // R9
endmodule

// File: tb/test_task_slot_sched.sv
`timescale 1ns/1ps
module test_task_slot_sched;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] task_en = '0;
    logic         lock_req = 1'b0;
    logic [1:0]   lock_tid = '0;
    logic         free_req = 1'b0;
    logic [1:0]   free_tid = '0;
    logic [N-1:0] long_busy = '0;
    logic         set_atomic = 1'b0;
    logic         set_debug = 1'b0;
    logic [1:0]   sel_tid;
    logic         sel_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        int    tid;
        bit    valid;
        string tag;
    } exp_t;
    exp_t sb[$];

    // Staged stimulus, applied by tick().
    logic [N-1:0] s_en = '0, s_busy = '0;
    bit s_lreq, s_freq, s_sa, s_sd;
    int s_ltid, s_ftid;

    // Reference state following the requirements.
    int m_cur = 0;
    bit m_val = 0, m_lock = 0, m_pend = 0, m_atom = 0;
    int m_owner = 0;

    always #2.5 clk = ~clk;

    task_slot_sched i_task_slot_sched (
        .clk(clk), .rst_n(rst_n), .task_en(task_en),
        .lock_req(lock_req), .lock_tid(lock_tid),
        .free_req(free_req), .free_tid(free_tid),
        .long_busy(long_busy), .set_atomic(set_atomic), .set_debug(set_debug),
        .sel_tid(sel_tid), .sel_valid(sel_valid)
    );

    task automatic check(input string tag, input int exp_tid, input bit exp_v);
        bit ok;
        checks++;
        ok = exp_v ? (sel_valid && int'(sel_tid) == exp_tid) : !sel_valid;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got tid=%0d valid=%0b, expected tid=%0d valid=%0b",
                     tag, sel_tid, sel_valid, exp_tid, exp_v);
        end
    endtask

    // Driver: apply staged inputs, advance the reference, queue the expectation.
    task automatic tick(input string tag);
        exp_t e;
        bit nl, np, hold;
        int no;
        @(negedge clk);
        task_en = s_en; long_busy = s_busy;
        lock_req = s_lreq; lock_tid = 2'(s_ltid);
        free_req = s_freq; free_tid = 2'(s_ftid);
        set_atomic = s_sa; set_debug = s_sd;
        nl = m_lock; np = m_pend; no = m_owner;
        if (m_lock) begin
            if (!s_en[m_owner]) begin nl = 0; np = 0; end
            else if ((s_freq && s_ftid == m_owner) || m_pend) begin
                if (s_busy[m_owner]) np = 1;
                else begin nl = 0; np = 0; end
            end
        end else if (s_lreq && s_en[s_ltid]) begin
            nl = 1; no = s_ltid; np = 0;
        end
        hold = m_atom && m_val && s_en[m_cur] && s_busy[m_cur];
        if (nl) begin m_cur = no; m_val = 1; end
        else if (!hold) begin
            bit found = 0;
            for (int k = 1; k <= N; k++) begin
                if (!found && s_en[(m_cur + k) % N]) begin
                    found = 1; m_cur = (m_cur + k) % N;
                end
            end
            m_val = found;
        end
        m_lock = nl; m_pend = np; m_owner = no;
        if (s_sd) m_atom = 0; else if (s_sa) m_atom = 1;
        e.tid = m_cur; e.valid = m_val; e.tag = tag;
        sb.push_back(e);
        s_lreq = 0; s_freq = 0; s_sa = 0; s_sd = 0;
    endtask

    // Monitor: compare after each edge has settled.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, e.tid, e.valid);
            end
        end
    end

    // Watchdog.
    initial begin
        #(5ns * 5000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        s_en = 4'b1111;
        repeat (4) tick("R2");
        s_en = 4'b0101;
        repeat (3) tick("R2");
        s_en = 4'b0000;
        tick("R2");
        s_en = 4'b1111;
        tick("R2");
        s_busy = 4'(1 << m_cur);
        tick("R1");
        s_busy = '0;

        s_lreq = 1; s_ltid = 2;
        tick("R3");
        tick("R3");
        tick("R3");
        s_lreq = 1; s_ltid = 1;
        tick("R6");
        s_freq = 1; s_ftid = 0;
        tick("R6");
        s_freq = 1; s_ftid = 2; s_busy = 4'b0100;
        tick("R5");
        tick("R5");
        s_busy = '0;
        tick("R5");
        tick("R4");

        s_lreq = 1; s_ltid = 1;
        tick("R4");
        s_freq = 1; s_ftid = 1;
        tick("R4");

        s_lreq = 1; s_ltid = 3;
        tick("R7");
        s_en = 4'b0111;
        tick("R7");
        s_lreq = 1; s_ltid = 3;
        tick("R7");

        s_sa = 1;
        tick("R8");
        s_busy = 4'(1 << m_cur);
        tick("R8");
        tick("R8");
        s_busy = '0;
        tick("R8");
        s_sd = 1; s_busy = 4'(1 << m_cur);
        tick("R9");
        s_busy = 4'(1 << m_cur);
        tick("R9");
        s_sa = 1; s_sd = 1;
        tick("R9");
        s_busy = 4'(1 << m_cur);
        tick("R9");
        s_busy = '0;

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule